// File: doc/BRIEF.md
# Shutter Setting Capture for a Progressive-Scan Sensor Timing Generator

This block takes the electronic shutter setting of a progressive-scan image-sensor timing generator and turns it into a registered configuration for the shutter pulse logic. A select input picks the input method. In parallel mode, three speed pins and two mode pins are sampled continuously. In serial mode, the same three speed pins become a strobe, a shift clock and a data line. A shift register collects the word, and the rising edge of the strobe copies it into the active configuration as a single step.

The active configuration is a two-bit shutter mode and a speed code. The mode is decoded into a one-hot selection of four modes: flickerless, fast, slow and shutter off. A random-trigger enable gates the trigger input. When the enable is high, each rising trigger edge produces one single-cycle start pulse for the exposure logic. Every asynchronous input passes through a two-stage synchronizer, and all edges are found after synchronization. The waveform of the discharge pulse itself is produced elsewhere.

Top module: `shutter_cfg_if`

## Requirements
- R1: While rst_n is low, cfg_mode is 2'b11, shut_sel is 4'b1000, cfg_speed is 7 (the value of the pulled-up pins), and trig_start is 0.
- R2: With sel_serial low, after at most four clock cycles cfg_mode equals {mode_pin[1], mode_pin[0]} and cfg_speed equals spd_pin zero-extended to SPD_W bits.
- R3: shut_sel is one-hot. Bit 0 stands for flickerless (cfg_mode 00), bit 1 for faster than 1/60 s (01), bit 2 for slower than 1/60 s (10), and bit 3 for shutter off (11).
- R4: With sel_serial high, each rising edge of spd_pin[1] shifts in spd_pin[2]. The word is SPD_W+2 bits long and is sent MSB first. The first two bits become cfg_mode (the first bit is cfg_mode[1]); the remaining bits become cfg_speed, MSB first.
- R5: In serial mode, the active configuration changes only on a rising edge of spd_pin[0]. Shifting bits in and changing mode_pin leave cfg_mode, cfg_speed and shut_sel unchanged.
- R6: When a strobe rise and a shift-clock rise are seen in the same cycle, the configuration takes the word from before that bit, and the bit is still shifted in.
- R7: On a switch from parallel to serial, the last parallel setting is kept until the first strobe. On a switch back to parallel, the outputs follow the pins again.
- R8: With rtrig_en high, each rising edge of trig_in gives exactly one trig_start pulse, one cycle wide, within four cycles. This holds even if trig_in stays high.
- R9: With rtrig_en low, trig_in edges produce no trig_start pulse.
- R10: If more than SPD_W+2 bits are shifted before a strobe, only the last SPD_W+2 bits are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_serial | input | 1 | 0: parallel pins, 1: serial port |
| spd_pin | input | 3 | Speed bits; in serial mode, bit 0 is the strobe, bit 1 the shift clock and bit 2 the data |
| mode_pin | input | 2 | Shutter mode bits used in parallel mode |
| rtrig_en | input | 1 | Enables the random-trigger start |
| trig_in | input | 1 | Asynchronous trigger input |
| cfg_speed | output | SPD_W | Active speed code |
| cfg_mode | output | 2 | Active shutter mode bits |
| shut_sel | output | 4 | One-hot decoded shutter mode |
| trig_start | output | 1 | Single-cycle exposure start pulse |

## Verification
The serial strobe and the shift clock can rise in the same synchronized cycle. If they do, a copy and a shift write the shift register's neighbourhood together. The bench provokes this by raising both pins on the same falling clock edge after a full word has been loaded. It then checks that the configuration holds the word from before the extra bit. A second, isolated strobe must then show that same word moved left by one with the new bit appended.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;
  localparam int PAR_SPD_W = 3;
  localparam int MODE_W    = 2;
  localparam int NUM_MODES = 4;

  typedef enum logic [1:0] {
    SHM_FLICKERLESS = 2'b00,
    SHM_FAST        = 2'b01,
    SHM_SLOW        = 2'b10,
    SHM_OFF         = 2'b11
  } shm_e;

  function automatic logic [NUM_MODES-1:0] shm_onehot(input logic [MODE_W-1:0] m);
    logic [NUM_MODES-1:0] r;
    r = '0;
    r[m] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/shcfg_sync.sv
module shcfg_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/shcfg_edge.sv
module shcfg_edge #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;
endmodule

// File: rtl/shcfg_shift.sv
module shcfg_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/shutter_cfg_if.sv
module shutter_cfg_if
  import shcfg_pkg::*;
#(
  parameter int SPD_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_serial,
  input  logic [2:0]       spd_pin,
  input  logic [1:0]       mode_pin,
  input  logic             rtrig_en,
  input  logic             trig_in,
  output logic [SPD_W-1:0] cfg_speed,
  output logic [1:0]       cfg_mode,
  output logic [3:0]       shut_sel,
  output logic             trig_start
);
  localparam int WORD_W = SPD_W + MODE_W;
  localparam int ASY_W  = PAR_SPD_W + MODE_W + 3;
  // Reset value of the synchronizers: speed and mode pins pulled up,
  // select, enable and trigger low.
  localparam logic [ASY_W-1:0] ASY_RST = {3'b000, 2'b11, 3'b111};
  localparam logic [WORD_W-1:0] RST_WORD = {SHM_OFF, SPD_W'(7)};

  // Synchronized inputs
  logic [ASY_W-1:0] asy_s;
  logic [2:0]       spd_s;
  logic [1:0]       mode_s;
  logic             sel_s, en_s, trig_s;

  shcfg_sync #(.W(ASY_W), .STAGES(SYNC_STAGES), .RST_VAL(ASY_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({trig_in, rtrig_en, sel_serial, mode_pin, spd_pin}),
    .q(asy_s)
  );

  assign spd_s  = asy_s[2:0];
  assign mode_s = asy_s[4:3];
  assign sel_s  = asy_s[5];
  assign en_s   = asy_s[6];
  assign trig_s = asy_s[7];

  // Edge events, named for the checker
  logic [2:0] rises;
  logic       strobe_rise, sclk_rise, trig_rise;

  shcfg_edge #(.W(3)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl({trig_s, spd_s[1], spd_s[0]}),
    .rise(rises)
  );

  assign strobe_rise = rises[0];
  assign sclk_rise   = rises[1];
  assign trig_rise   = rises[2];

  // Serial shift register (shifts only in serial mode)
  logic [WORD_W-1:0] shreg;
  logic              shift_en;

  assign shift_en = sel_s & sclk_rise;

  shcfg_shift #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en),
    .din(spd_s[2]),
    .q(shreg)
  );

  // Active configuration register
  logic [WORD_W-1:0] par_word, cfg_q;
  logic              load_par, load_ser;

  assign par_word = {mode_s, SPD_W'(spd_s)};
  assign load_par = ~sel_s;
  assign load_ser = sel_s & strobe_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_q <= RST_WORD;
    else if (load_par) cfg_q <= par_word;
    else if (load_ser) cfg_q <= shreg;
  end

  assign cfg_mode  = cfg_q[WORD_W-1 -: MODE_W];
  assign cfg_speed = cfg_q[SPD_W-1:0];
  assign shut_sel  = shm_onehot(cfg_mode);

  // Random-trigger start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_start <= 1'b0;
    else        trig_start <= trig_rise & en_s;
  end
endmodule

// File: rtl/shutter_cfg_if_chk.sv
module shutter_cfg_if_chk #(
  parameter int WORD_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_s,
  input logic              strobe_rise,
  input logic              en_s,
  input logic              trig_start,
  input logic [3:0]        shut_sel,
  input logic [WORD_W-1:0] shreg,
  input logic [WORD_W-1:0] par_word,
  input logic [WORD_W-1:0] cfg_q
);
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(shut_sel) == 1);

  assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> cfg_q == $past(par_word));

  assert_hold_serial_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && !strobe_rise) |=> $stable(cfg_q));

  assert_strobe_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_s && strobe_rise) |=> cfg_q == $past(shreg));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_start |=> !trig_start);

  assert_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !trig_start);
endmodule

bind shutter_cfg_if shutter_cfg_if_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .strobe_rise(strobe_rise),
  .en_s(en_s), .trig_start(trig_start), .shut_sel(shut_sel),
  .shreg(shreg), .par_word(par_word), .cfg_q(cfg_q)
);

// File: tb/shutter_cfg_if_bench.sv
`timescale 1ns/1ps
module shutter_cfg_if_bench;
  localparam int SPD_W = 8;
  localparam int WORD_W = SPD_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_serial = 1'b0;
  logic [2:0] spd_pin = 3'b111;
  logic [1:0] mode_pin = 2'b11;
  logic rtrig_en = 1'b0;
  logic trig_in = 1'b0;
  logic [SPD_W-1:0] cfg_speed;
  logic [1:0] cfg_mode;
  logic [3:0] shut_sel;
  logic trig_start;

  int errors = 0;
  int checks = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  shutter_cfg_if #(.SPD_W(SPD_W)) u_shutter_cfg_if (
    .clk(clk), .rst_n(rst_n), .sel_serial(sel_serial), .spd_pin(spd_pin),
    .mode_pin(mode_pin), .rtrig_en(rtrig_en), .trig_in(trig_in),
    .cfg_speed(cfg_speed), .cfg_mode(cfg_mode), .shut_sel(shut_sel),
    .trig_start(trig_start)
  );

  always @(negedge clk) if (trig_start) pulse_cnt++;

  // {mode[1:0], speed pins[2:0], expected one-hot[3:0]}
  localparam logic [8:0] PVEC [0:7] = '{
    9'b00_101_0001, 9'b01_010_0010, 9'b10_111_0100, 9'b11_001_1000,
    9'b00_011_0001, 9'b10_000_0100, 9'b01_110_0010, 9'b11_111_1000
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    spd_pin[2] = b; waitn(3);
    spd_pin[1] = 1'b1; waitn(3);
    spd_pin[1] = 1'b0; waitn(3);
  endtask

  task automatic send_word(input logic [WORD_W-1:0] w);
    for (int i = WORD_W - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic strobe();
    spd_pin[0] = 1'b1; waitn(4);
    spd_pin[0] = 1'b0; waitn(4);
  endtask

  task automatic chk_word(input string req, input logic [WORD_W-1:0] w);
    chk(req, {30'd0, cfg_mode}, {30'd0, w[WORD_W-1 -: 2]});
    chk(req, 32'(cfg_speed), 32'(w[SPD_W-1:0]));
    chk(req, {28'd0, shut_sel}, 32'(4'b0001 << w[WORD_W-1 -: 2]));
  endtask

  initial begin
    logic [WORD_W-1:0] w1, w2, w3;
    waitn(3);
    // R1: reset state
    chk("R1 mode", {30'd0, cfg_mode}, 32'h3);
    chk("R1 sel", {28'd0, shut_sel}, 32'h8);
    chk("R1 speed", 32'(cfg_speed), 32'd7);
    chk("R1 trig", {31'd0, trig_start}, 32'd0);
    rst_n = 1'b1;
    waitn(3);

    // R2, R3: parallel vector table
    for (int i = 0; i < 8; i++) begin
      mode_pin = PVEC[i][8:7];
      spd_pin  = PVEC[i][6:4];
      waitn(5);
      chk("R2 mode", {30'd0, cfg_mode}, {30'd0, PVEC[i][8:7]});
      chk("R2 speed", 32'(cfg_speed), {29'd0, PVEC[i][6:4]});
      chk("R3 onehot", {28'd0, shut_sel}, {28'd0, PVEC[i][3:0]});
    end

    // R7: into serial mode, last parallel value (11/111) kept
    sel_serial = 1'b1; spd_pin = 3'b000; waitn(6);
    mode_pin = 2'b00; waitn(6);
    chk_word("R7 hold after switch", {2'b11, 8'd7});

    // R4, R5: shift a word, no change before strobe
    w1 = {2'b01, 8'hA5};
    send_word(w1);
    mode_pin = 2'b10; waitn(5);
    chk_word("R5 no strobe", {2'b11, 8'd7});
    strobe();
    chk_word("R4 serial load", w1);

    // R10: extra leading bits discarded
    w2 = {2'b10, 8'h3C};
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    send_word(w2);
    chk_word("R5 hold w1", w1);
    strobe();
    chk_word("R10 last bits", w2);

    // R6: strobe and shift clock rise together
    w3 = {2'b00, 8'h5A};
    send_word(w3);
    spd_pin[2] = 1'b1; waitn(3);
    spd_pin[1] = 1'b1; spd_pin[0] = 1'b1; waitn(4);
    spd_pin[1] = 1'b0; spd_pin[0] = 1'b0; waitn(4);
    chk_word("R6 same-cycle copy", w3);
    strobe();
    chk_word("R6 shifted after", {w3[WORD_W-2:0], 1'b1});

    // R7: back to parallel
    sel_serial = 1'b0; mode_pin = 2'b10; spd_pin = 3'b011; waitn(6);
    chk_word("R7 parallel again", {2'b10, 8'd3});

    // R8: trigger enabled
    rtrig_en = 1'b1; waitn(5);
    pulse_cnt = 0;
    trig_in = 1'b1; waitn(20);
    chk("R8 one pulse held high", 32'(pulse_cnt), 32'd1);
    trig_in = 1'b0; waitn(5);
    pulse_cnt = 0;
    trig_in = 1'b1; waitn(4);
    chk("R8 pulse within 4", 32'(pulse_cnt), 32'd1);
    trig_in = 1'b0; waitn(5);

    // R9: trigger disabled
    rtrig_en = 1'b0; waitn(5);
    pulse_cnt = 0;
    trig_in = 1'b1; waitn(6); trig_in = 1'b0; waitn(6);
    trig_in = 1'b1; waitn(6); trig_in = 1'b0; waitn(6);
    chk("R9 no pulse", 32'(pulse_cnt), 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule